// File: doc/BRIEF.md
# Partitioned LRU Way Selector

This block keeps the recency order of the four ways in every set of a four-way set-associative read cache. On each lookup it names a victim way, which is the way the cache fills on a miss. On the following clock edge it records the way that was hit or filled as the most recently used way in that set. The victim output is combinational. It depends on the addressed set, the access type (instruction fetch or data read) and the active partition mode.

There are three partition modes. In the first, both access types share all four ways. In the second, instruction fetches replace only in ways 0–1 and data reads only in ways 2–3. In the third, instruction fetches replace in ways 0–2 and data reads only in way 3. A hit may touch any way, whatever the partition. The mode input is captured only in cycles with no lookup, so a lookup always sees a stable policy.

Top module: `lru_way_picker`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) gives every set the order way 0 oldest, then way 1, then way 2, with way 3 newest. It also makes mode 0 active.
- R2: A lookup (`lookup` high at a clock edge) makes `touch_way` the newest way in set `set_idx`. Ways that were newer than it each age by one place. Other sets keep their order.
- R3: In mode 0, `victim` is the oldest of all four ways in the addressed set, for either access type.
- R4: In mode 1, `victim` is the older of ways 0 and 1 for an instruction fetch (`is_data`=0), and the older of ways 2 and 3 for a data read (`is_data`=1).
- R5: In mode 2, `victim` is the oldest of ways 0, 1 and 2 for an instruction fetch. It is always way 3 for a data read.
- R6: Mode encoding on `mode_in`: 0 selects the shared policy, 1 the two-and-two split, and 2 the three-and-one split. The value 3 acts as mode 0.
- R7: `mode_in` is loaded into the active mode only at a clock edge where `lookup` is low. A change made while `lookup` is high has no effect on `victim` until a cycle without a lookup.
- R8: `victim` follows the current state combinationally. With `lookup` low, no set's order changes, whatever `set_idx`, `touch_way` and `is_data` do.
- R9: If several allowed ways tie in age, the lowest-numbered one is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookup | input | 1 | Lookup strobe; updates recency at the clock edge |
| set_idx | input | $clog2(SETS) | Addressed set |
| touch_way | input | 2 | Way that was hit or filled by this lookup |
| is_data | input | 1 | 1 = data read, 0 = instruction fetch |
| mode_in | input | 2 | Requested partition mode |
| victim | output | 2 | Way to replace for the addressed set and access type |

## Verification
The hardest case to reach from the ports is a `mode_in` change that arrives while lookups are still running. If the design ignores the mode hold rule, this shows up only as a victim chosen under the wrong partition. The bench holds `lookup` high over a change to `mode_in` and drives an access type whose allowed subsets differ between the two modes. It then checks that the victim still follows the old partition, and that the new one takes effect after a single idle cycle. Long touch sequences also drive a way that lies outside the current access type's partition. This confirms that hits still update the shared recency order.

// File: rtl/lru_way_picker.sv
module lru_way_picker #(
  parameter int SETS = 8,
  localparam int IW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lookup,
  input  logic [IW-1:0] set_idx,
  input  logic [1:0]    touch_way,
  input  logic          is_data,
  input  logic [1:0]    mode_in,
  output logic [1:0]    victim
);

  logic [1:0] age_q [SETS][4];
  logic [1:0] mode_q;
  logic [3:0] allow;
  logic [SETS*8-1:0] age_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 2'd0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < 4; w++)
          age_q[s][w] <= 2'(3 - w);
    end else if (lookup) begin
      for (int w = 0; w < 4; w++)
        if (w == int'(touch_way))
          age_q[set_idx][w] <= 2'd0;
        else if (age_q[set_idx][w] < age_q[set_idx][touch_way])
          age_q[set_idx][w] <= age_q[set_idx][w] + 2'd1;
    end else begin
      mode_q <= (mode_in == 2'd3) ? 2'd0 : mode_in;
    end
  end

  always_comb begin
    case (mode_q)
      2'd1:    allow = is_data ? 4'b1100 : 4'b0011;
      2'd2:    allow = is_data ? 4'b1000 : 4'b0111;
      default: allow = 4'b1111;
    endcase
  end

  always_comb begin
    logic       found;
    logic [1:0] best_age;
    found    = 1'b0;
    best_age = 2'd0;
    victim   = 2'd0;
    for (int w = 0; w < 4; w++)
      if (allow[w] && (!found || age_q[set_idx][w] > best_age)) begin
        found    = 1'b1;
        best_age = age_q[set_idx][w];
        victim   = 2'(w);
      end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_flat
    for (genvar w = 0; w < 4; w++) begin : g_way
      assign age_flat[s*8 + w*2 +: 2] = age_q[s][w];
    end
  end

endmodule

module lru_way_picker_chk #(
  parameter int SETS = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          lookup,
  input logic [IW-1:0] set_idx,
  input logic [1:0]    touch_way,
  input logic          is_data,
  input logic [1:0]    victim,
  input logic [1:0]    mode_q,
  input logic [SETS*8-1:0] age_flat
);

  assert_instr_split_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd1 && !is_data) |-> victim < 2'd2);

  assert_data_split_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd1 && is_data) |-> victim >= 2'd2);

  assert_data_single_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd2 && is_data) |-> victim == 2'd3);

  assert_instr_three_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd2 && !is_data) |-> victim != 2'd3);

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
    lookup |=> mode_q == $past(mode_q));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !lookup |=> $stable(age_flat));

  assert_touched_newest_R2: assert property (@(posedge clk) disable iff (rst)
    lookup |=> !(set_idx == $past(set_idx) && !(mode_q == 2'd2 && is_data)
                 && victim == $past(touch_way)));

endmodule

bind lru_way_picker lru_way_picker_chk #(.SETS(SETS), .IW(IW)) u_chk (.*);

// File: tb/lru_way_picker_tb.sv
module lru_way_picker_tb;

  localparam int SETS = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst, lookup, is_data;
  logic [IW-1:0] set_idx;
  logic [1:0] touch_way, mode_in, victim;

  int checks = 0;
  int fails = 0;
  int stamp [SETS][4];
  int tick;
  int mm;

  lru_way_picker #(.SETS(SETS)) u_dut (.*);

  always #5 clk = ~clk;

  // vector fields: mode[7:6] set[5:3] way[2:1] data[0]
  localparam logic [7:0] VEC [24] = '{
    {2'd0,3'd0,2'd0,1'b0}, {2'd0,3'd0,2'd1,1'b1}, {2'd0,3'd0,2'd3,1'b0},
    {2'd0,3'd0,2'd2,1'b1}, {2'd0,3'd5,2'd2,1'b0}, {2'd0,3'd0,2'd1,1'b0},
    {2'd1,3'd0,2'd0,1'b0}, {2'd1,3'd0,2'd3,1'b1}, {2'd1,3'd0,2'd2,1'b0},
    {2'd1,3'd2,2'd1,1'b1}, {2'd1,3'd2,2'd3,1'b0}, {2'd1,3'd2,2'd2,1'b1},
    {2'd2,3'd0,2'd3,1'b1}, {2'd2,3'd0,2'd0,1'b0}, {2'd2,3'd0,2'd2,1'b0},
    {2'd2,3'd7,2'd1,1'b0}, {2'd2,3'd7,2'd3,1'b0}, {2'd2,3'd7,2'd0,1'b1},
    {2'd3,3'd7,2'd2,1'b0}, {2'd3,3'd7,2'd0,1'b1}, {2'd3,3'd2,2'd1,1'b0},
    {2'd0,3'd5,2'd0,1'b1}, {2'd0,3'd5,2'd3,1'b0}, {2'd1,3'd5,2'd1,1'b0}
  };

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: victim=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_victim(input int s, input bit d, input int m);
    int best = -1;
    for (int w = 0; w < 4; w++) begin
      bit ok;
      case (m)
        1: ok = d ? (w >= 2) : (w < 2);
        2: ok = d ? (w == 3) : (w < 3);
        default: ok = 1'b1;
      endcase
      if (ok && (best < 0 || stamp[s][w] < stamp[s][best])) best = w;
    end
    return best;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 4; w++) stamp[s][w] = w;
    tick = 4;
    mm = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lookup = 1'b0; mode_in = 2'd0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic set_mode(input int m);
    @(negedge clk);
    lookup = 1'b0; mode_in = 2'(m);
    @(posedge clk);
    mm = (m == 3) ? 0 : m;
  endtask

  task automatic access(input int s, input int w, input bit d, input string req);
    @(negedge clk);
    set_idx = IW'(s); touch_way = 2'(w); is_data = d; lookup = 1'b1;
    #1 check(int'(victim), model_victim(s, d, mm), req);
    @(posedge clk);
    stamp[s][w] = tick++;
  endtask

  task automatic probe(input int s, input bit d, input int exp, input string req);
    @(negedge clk);
    lookup = 1'b0; set_idx = IW'(s); is_data = d;
    #1 check(int'(victim), exp, req);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: victim=%0d expected=finish", victim);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; lookup = 1'b0; set_idx = '0; touch_way = '0; is_data = 1'b0; mode_in = 2'd0;
    repeat (2) @(posedge clk);
    do_reset();

    for (int s = 0; s < SETS; s++) probe(s, s[0], 0, "R1 reset mode0");
    set_mode(1);
    probe(3, 1'b0, 0, "R1 R4 reset instr");
    probe(3, 1'b1, 2, "R1 R4 reset data");
    set_mode(2);
    probe(4, 1'b1, 3, "R1 R5 reset data");
    probe(4, 1'b0, 0, "R1 R5 reset instr");
    set_mode(3);
    probe(1, 1'b1, 0, "R6 code 3 as mode0");
    set_mode(0);

    // R2 R3 R9: shared order, touched way becomes newest
    access(6, 0, 1'b0, "R3 before touch");
    probe(6, 1'b0, 1, "R2 way0 now newest");
    probe(5, 1'b0, 0, "R2 other set untouched");

    foreach (VEC[i]) begin
      int m = int'(VEC[i][7:6]);
      if (((m == 3) ? 0 : m) != mm || m != int'(mode_in)) set_mode(m);
      access(int'(VEC[i][5:3]), int'(VEC[i][2:1]), VEC[i][0], "R2 R3 R4 R5 R9 table");
    end

    // R7: mode change under an active lookup is ignored
    set_mode(1);
    @(negedge clk);
    set_idx = IW'(0); touch_way = 2'd0; is_data = 1'b1; lookup = 1'b1; mode_in = 2'd2;
    #1 check(int'(victim), model_victim(0, 1'b1, 1), "R7 lookup held");
    @(posedge clk);
    stamp[0][0] = tick++;
    access(0, 1, 1'b1, "R7 old mode kept");
    set_mode(2);
    probe(0, 1'b1, 3, "R7 new mode after idle");

    // R8: idle cycles with wiggling inputs change nothing
    set_mode(0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      lookup = 1'b0; set_idx = IW'(k); touch_way = 2'(k); is_data = k[0];
      @(posedge clk);
    end
    for (int s = 0; s < SETS; s++)
      probe(s, 1'b0, model_victim(s, 1'b0, 0), "R8 idle no change");

    do_reset();
    probe(0, 1'b0, 0, "R1 second reset");
    probe(5, 1'b1, 0, "R1 second reset set5");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule